// File: doc/BRIEF.md
# Four-Channel DMA Port Bandwidth Arbiter

Four DMA channels share a single bus port. Each channel asks for the port while it still has bytes to move, and it presents its remaining byte count. The arbiter gives the port to one channel at a time. For every beat the bus accepts, it states how many bytes that beat carries. The arbiter takes the port back when the channel's time slice is spent or when its transfer finishes. It then passes the port on in rotating order.

Each channel has a mode register with a 4-bit slice code. Codes 0 through 10 allow a slice of 2^code bytes. Codes 11 through 14 act like code 10. Code 15 turns sharing off, so the channel keeps the port until its transfer is done, even while others wait. The code is sampled when a grant starts. A new value written during a slice therefore applies from the channel's next grant onward.

Top module: `bwshare_arb`

## Requirements
- R1: The mode registers of channels 0..3 sit at byte addresses 0x100, 0x180, 0x200 and 0x280. The slice code is bits 27:24 of the 32-bit word and reads back in the same place. All other bits read zero. A write to any other address changes no register, and reading any other address returns zero.
- R2: After reset every slice code reads 8, so a lone channel moves 256 bytes per grant.
- R3: At most one bit of `gnt` is set at a time. A grant only starts for a channel that requested in the cycle before.
- R4: With codes 0..10, a grant ends after exactly 2^code bytes unless the transfer ends first.
- R5: Codes 11..14 give the same 1024-byte slice as code 10.
- R6: With code 15, the holder keeps the port until its remaining count reaches zero, even if other channels request.
- R7: A new grant goes to the first requesting channel after the previous holder, in ascending order with wrap-around.
- R8: `beat_bytes` is the smallest of 4, the remaining count and the bytes left in the slice. It is never 0 while `beat_valid` is high. Only beats with `beat_ready` high count.
- R9: A grant also ends when the remaining count reaches zero. Between two grants `gnt` is all zero for one cycle.
- R10: A code written while a grant is active does not change that slice. It applies from the next grant.
- R11: After reset, `gnt` is zero and `beat_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_addr | input | 12 | Register byte address |
| cfg_wdata | input | 32 | Write data, code in bits 27:24 |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| ch_req | input | 4 | Per-channel request |
| ch_remain | input | 64 | Per-channel remaining bytes, 16 bits each, channel 0 in the low bits |
| beat_ready | input | 1 | Bus accepts the current beat |
| gnt | output | 4 | One-hot grant |
| beat_valid | output | 1 | A beat is offered for the granted channel |
| beat_ch | output | 2 | Channel that owns the current beat |
| beat_bytes | output | 3 | Bytes in the current beat (1..4) |

## Verification
The bench builds the arbiter with its defaults: four channels, 16-bit remaining counts and 4-byte beats. The 16-bit counts allow transfers of several kilobytes. These cross the 1024-byte cap of the reserved codes and also show the 256-byte reset slice over several grants. With four channels the bench can walk a full rotation with wrap-around. It can also show a channel with code 15 keeping another one out for a 300-byte transfer. Slice codes 0 and 1 make the bench trim beats at the slice edge, and short lengths make it trim beats at the end of a transfer.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

  localparam int CODE_W    = 4;
  localparam int FIELD_LSB = 24;
  localparam int SLICE_W   = 11;

  typedef logic [CODE_W-1:0] bw_code_t;

  localparam bw_code_t CODE_RST  = 4'h8;
  localparam bw_code_t CODE_TOP  = 4'hA;
  localparam bw_code_t CODE_HOLD = 4'hF;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } arb_st_e;

  // Byte quota for one grant; reserved codes saturate at the largest slice.
  function automatic logic [SLICE_W-1:0] slice_limit(input bw_code_t c);
    if (c <= CODE_TOP) slice_limit = SLICE_W'(1) << c;
    else               slice_limit = SLICE_W'(1) << CODE_TOP;
  endfunction

endpackage

// File: rtl/bwa_rst_sync.sv
module bwa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/bwa_mode_regs.sv
module bwa_mode_regs
  import bwa_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h100,
  parameter int STRIDE = 'h80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [CODE_W-1:0]     wfield,
  output logic [31:0]           rdata,
  output logic [NCH*CODE_W-1:0] codes
);

  logic [NCH-1:0] hit;

  for (genvar i = 0; i < NCH; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(BASE + i * STRIDE);
    bw_code_t code_q;
    logic     wen;

    assign hit[i] = (addr == OFS);
    assign wen    = wr_en & hit[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   code_q <= CODE_RST;
      else if (wen) code_q <= wfield;
    end

    assign codes[i*CODE_W +: CODE_W] = code_q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (hit[i]) rdata[FIELD_LSB +: CODE_W] = codes[i*CODE_W +: CODE_W];
    end
  end

endmodule

// File: rtl/bwa_rr_pick.sv
module bwa_rr_pick #(
  parameter int NCH = 4,
  parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] elig,
  input  logic [CW-1:0]  last,
  output logic           any,
  output logic [CW-1:0]  pick
);

  // Scan from farthest to nearest so the nearest eligible channel after
  // the previous holder is the one that stays selected.
  always_comb begin
    int idx;
    any  = 1'b0;
    pick = '0;
    for (int k = NCH; k >= 1; k--) begin
      idx = (int'(last) + k) % NCH;
      if (elig[idx]) begin
        any  = 1'b1;
        pick = CW'(idx);
      end
    end
  end

endmodule

// File: rtl/bwa_beat_size.sv
module bwa_beat_size #(
  parameter int LEN_W   = 16,
  parameter int BEAT    = 4,
  parameter int SLICE_W = 11,
  parameter int BB_W    = 3
) (
  input  logic [LEN_W-1:0]   rem,
  input  logic [SLICE_W-1:0] used,
  input  logic [SLICE_W-1:0] lim,
  input  logic               unlim,
  output logic [BB_W-1:0]    bytes,
  output logic               xfer_end,
  output logic               slice_end
);

  logic [SLICE_W-1:0] room;
  logic [LEN_W-1:0]   room_w;
  logic [LEN_W-1:0]   cand;

  assign room   = lim - used;
  assign room_w = LEN_W'(room);

  always_comb begin
    cand = LEN_W'(BEAT);
    if (rem < cand)              cand = rem;
    if (!unlim && room_w < cand) cand = room_w;
  end

  assign bytes     = BB_W'(cand);
  assign xfer_end  = (cand == rem);
  assign slice_end = !unlim && (cand == room_w);

endmodule

// File: rtl/bwshare_arb.sv
module bwshare_arb
  import bwa_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int LEN_W      = 16,
  parameter int BEAT_BYTES = 4,
  parameter int ADDR_W     = 12,
  parameter int REG_BASE   = 'h100,
  parameter int REG_STRIDE = 'h80,
  localparam int CH_W      = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BB_W      = $clog2(BEAT_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  input  logic [NCH-1:0]       ch_req,
  input  logic [NCH*LEN_W-1:0] ch_remain,
  input  logic                 beat_ready,
  output logic [NCH-1:0]       gnt,
  output logic                 beat_valid,
  output logic [CH_W-1:0]      beat_ch,
  output logic [BB_W-1:0]      beat_bytes
);

  logic rst_i_n;

  bwa_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // Mode registers
  logic [NCH*CODE_W-1:0] codes;
  logic                  unused_wdata;

  assign unused_wdata = ^{cfg_wdata[31:FIELD_LSB+CODE_W], cfg_wdata[FIELD_LSB-1:0]};

  bwa_mode_regs #(
    .NCH    (NCH),
    .ADDR_W (ADDR_W),
    .BASE   (REG_BASE),
    .STRIDE (REG_STRIDE)
  ) i_mode_regs (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .wr_en  (cfg_we),
    .addr   (cfg_addr),
    .wfield (cfg_wdata[FIELD_LSB +: CODE_W]),
    .rdata  (cfg_rdata),
    .codes  (codes)
  );

  // Per-channel eligibility
  logic [LEN_W-1:0] rem_arr [NCH];
  logic [NCH-1:0]   elig;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign rem_arr[i] = ch_remain[i*LEN_W +: LEN_W];
    assign elig[i]    = ch_req[i] && (rem_arr[i] != '0);
  end

  // State
  arb_st_e            st_q, st_n;
  logic [CH_W-1:0]    own_q;
  logic [SLICE_W-1:0] used_q, used_n;
  logic [SLICE_W-1:0] lim_q;
  logic               unlim_q;

  // Rotation
  logic            any_elig;
  logic [CH_W-1:0] pick;
  bw_code_t        code_pick;

  bwa_rr_pick #(
    .NCH (NCH),
    .CW  (CH_W)
  ) i_rr_pick (
    .elig (elig),
    .last (own_q),
    .any  (any_elig),
    .pick (pick)
  );

  assign code_pick = codes[pick*CODE_W +: CODE_W];

  // Beat sizing
  logic [LEN_W-1:0] own_rem;
  logic [BB_W-1:0]  size_raw;
  logic             xfer_end;
  logic             slice_end;

  assign own_rem = rem_arr[own_q];

  bwa_beat_size #(
    .LEN_W   (LEN_W),
    .BEAT    (BEAT_BYTES),
    .SLICE_W (SLICE_W),
    .BB_W    (BB_W)
  ) i_beat_size (
    .rem       (own_rem),
    .used      (used_q),
    .lim       (lim_q),
    .unlim     (unlim_q),
    .bytes     (size_raw),
    .xfer_end  (xfer_end),
    .slice_end (slice_end)
  );

  // Next state
  logic busy;
  logic grant_ld;
  logic fire;
  logic release_now;
  logic cnt_en;

  assign busy        = (st_q == ST_BUSY);
  assign grant_ld    = !busy && any_elig;
  assign fire        = busy && elig[own_q] && beat_ready;
  assign release_now = busy && (!elig[own_q] || (fire && (xfer_end || slice_end)));
  assign cnt_en      = grant_ld || fire;

  always_comb begin
    st_n = st_q;
    case (st_q)
      ST_IDLE: if (grant_ld)    st_n = ST_BUSY;
      ST_BUSY: if (release_now) st_n = ST_IDLE;
      default:                  st_n = ST_IDLE;
    endcase
  end

  always_comb begin
    if (grant_ld) used_n = '0;
    else          used_n = used_q + SLICE_W'(size_raw);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= ST_IDLE;
      own_q   <= CH_W'(NCH - 1);
      used_q  <= '0;
      lim_q   <= '0;
      unlim_q <= 1'b0;
    end else begin
      st_q <= st_n;
      if (grant_ld) begin
        own_q   <= pick;
        lim_q   <= slice_limit(code_pick);
        unlim_q <= (code_pick == CODE_HOLD);
      end
      if (cnt_en) used_q <= used_n;
    end
  end

  // Outputs
  for (genvar i = 0; i < NCH; i++) begin : g_gnt
    assign gnt[i] = busy && (own_q == CH_W'(i));
  end

  assign beat_valid = busy && elig[own_q];
  assign beat_ch    = own_q;
  assign beat_bytes = beat_valid ? size_raw : '0;

endmodule

// File: rtl/bwa_chk.sv
module bwa_chk #(
  parameter int NCH        = 4,
  parameter int LEN_W      = 16,
  parameter int BEAT_BYTES = 4,
  parameter int CH_W       = 2,
  parameter int BB_W       = 3,
  parameter int SLICE_W    = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NCH-1:0]     gnt,
  input logic [NCH-1:0]     ch_req,
  input logic               beat_valid,
  input logic               beat_ready,
  input logic [BB_W-1:0]    beat_bytes,
  input logic [LEN_W-1:0]   own_rem,
  input logic [SLICE_W-1:0] used_q,
  input logic [SLICE_W-1:0] lim_q,
  input logic               unlim_q
);

  // R3
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R3
  gnt_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && !(|$past(gnt))) |-> (|($past(ch_req) & gnt)));

  // R8
  beat_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_bytes != '0 && beat_bytes <= BB_W'(BEAT_BYTES)));

  // R4
  slice_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlim_q |-> (used_q <= lim_q));

  // R9
  grant_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && (|$past(gnt))) |-> (gnt == $past(gnt)));

  // R6
  hold_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlim_q && beat_valid && beat_ready && (LEN_W'(beat_bytes) != own_rem))
      |=> (gnt == $past(gnt)));

  // R10
  slice_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && (|$past(gnt))) |-> (lim_q == $past(lim_q) && unlim_q == $past(unlim_q)));

endmodule

bind bwshare_arb bwa_chk #(
  .NCH        (NCH),
  .LEN_W      (LEN_W),
  .BEAT_BYTES (BEAT_BYTES),
  .CH_W       (CH_W),
  .BB_W       (BB_W),
  .SLICE_W    (bwa_pkg::SLICE_W)
) i_bwa_chk (
  .clk        (clk),
  .rst_n      (rst_i_n),
  .gnt        (gnt),
  .ch_req     (ch_req),
  .beat_valid (beat_valid),
  .beat_ready (beat_ready),
  .beat_bytes (beat_bytes),
  .own_rem    (own_rem),
  .used_q     (used_q),
  .lim_q      (lim_q),
  .unlim_q    (unlim_q)
);

// File: tb/test_bwshare_arb.sv
`timescale 1ns/1ps
module test_bwshare_arb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [11:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [3:0]  ch_req;
  logic [63:0] ch_remain;
  logic        beat_ready;
  logic [3:0]  gnt;
  logic        beat_valid;
  logic [1:0]  beat_ch;
  logic [2:0]  beat_bytes;

  always #4 clk = ~clk;

  bwshare_arb i_bwshare_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .ch_req     (ch_req),
    .ch_remain  (ch_remain),
    .beat_ready (beat_ready),
    .gnt        (gnt),
    .beat_valid (beat_valid),
    .beat_ch    (beat_ch),
    .beat_bytes (beat_bytes)
  );

  int checks = 0;
  int errors = 0;

  // Channel model: remaining counts, loaded by tasks, drained by beats
  int   rem [4] = '{default: 0};
  int   ld_rem [4] = '{default: 0};
  logic ld_go = 1'b0;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      ch_req[i]            = (rem[i] != 0);
      ch_remain[i*16 +: 16] = 16'(rem[i]);
    end
  end

  // Slice log: one entry per completed grant
  int         s_ch [256];
  int         s_by [256];
  int         s_mx [256];
  int         ns = 0;
  int         acc = 0;
  int         mx = 0;
  int         lastch = 0;
  logic [3:0] gprev = 4'b0;

  always @(posedge clk) begin
    if (ld_go) begin
      for (int i = 0; i < 4; i++) rem[i] <= ld_rem[i];
    end else if (beat_valid && beat_ready) begin
      rem[beat_ch] <= rem[beat_ch] - int'(beat_bytes);
    end
    gprev <= gnt;
    if (beat_valid && beat_ready) begin
      acc    <= acc + int'(beat_bytes);
      mx     <= (int'(beat_bytes) > mx) ? int'(beat_bytes) : mx;
      lastch <= int'(beat_ch);
    end else if (gprev != 4'b0 && gnt == 4'b0 && ns < 256) begin
      s_ch[ns] <= lastch;
      s_by[ns] <= acc;
      s_mx[ns] <= mx;
      ns       <= ns + 1;
      acc      <= 0;
      mx       <= 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_code(input int ch, input int code);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = 12'('h100 + ch * 'h80);
    cfg_wdata = 32'(code) << 24;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic write_raw(input int addr, input logic [31:0] data);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = 12'(addr);
    cfg_wdata = data;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic read_reg(input int addr, output int data);
    @(negedge clk);
    cfg_addr = 12'(addr);
    #1;
    data = int'(cfg_rdata);
  endtask

  task automatic load(input int r0, input int r1, input int r2, input int r3);
    @(negedge clk);
    ld_rem[0] = r0; ld_rem[1] = r1; ld_rem[2] = r2; ld_rem[3] = r3;
    ld_go = 1'b1;
    @(negedge clk);
    ld_go = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(rem[0] == 0 && rem[1] == 0 && rem[2] == 0 && rem[3] == 0 && gnt == 4'b0)
               && n < 20000);
    repeat (2) @(negedge clk);
  endtask

  task automatic exp_slice(input string tag, input int idx, input int ch,
                           input int by, input int mxb);
    chk({tag, " slice channel"}, s_ch[idx], ch);
    chk({tag, " slice bytes"}, s_by[idx], by);
    if (mxb > 0) chk({tag, " largest beat"}, s_mx[idx], mxb);
  endtask

  // R11 R2: reset state, default code and default slice size
  task automatic t_reset();
    int d;
    int b;
    chk("R11 gnt after reset", int'(gnt), 0);
    chk("R11 beat_valid after reset", int'(beat_valid), 0);
    for (int c = 0; c < 4; c++) begin
      read_reg('h100 + c * 'h80, d);
      chk("R2 reset code readback", d, 32'h0800_0000);
    end
    b = ns;
    load(600, 0, 0, 0);
    wait_idle();
    chk("R2 default slice count", ns - b, 3);
    exp_slice("R2", b, 0, 256, 4);
    exp_slice("R2", b + 1, 0, 256, 4);
    exp_slice("R9 early end", b + 2, 0, 88, 4);
  endtask

  // R1: decode, field position, ignored address
  task automatic t_regs();
    int d;
    write_raw('h180, 32'hFFFF_FFFF);
    read_reg('h180, d);
    chk("R1 field only readback", d, 32'h0F00_0000);
    write_raw('h140, 32'h0300_0000);
    read_reg('h140, d);
    chk("R1 unmapped reads zero", d, 0);
    read_reg('h100, d);
    chk("R1 ch0 untouched", d, 32'h0800_0000);
    read_reg('h180, d);
    chk("R1 ch1 untouched", d, 32'h0F00_0000);
    read_reg('h200, d);
    chk("R1 ch2 untouched", d, 32'h0800_0000);
    read_reg('h280, d);
    chk("R1 ch3 untouched", d, 32'h0800_0000);
  endtask

  // R7: rotation after the last holder (channel 0), with wrap-around
  task automatic t_rr();
    int b;
    int order [8] = '{1, 2, 3, 0, 1, 2, 3, 0};
    for (int c = 0; c < 4; c++) write_code(c, 2);
    b = ns;
    load(8, 8, 8, 8);
    wait_idle();
    chk("R7 rotation slice count", ns - b, 8);
    for (int k = 0; k < 8; k++) exp_slice("R7 rotation", b + k, order[k], 4, 4);
    b = ns;
    load(0, 4, 0, 4);
    wait_idle();
    chk("R7 sparse count", ns - b, 2);
    exp_slice("R7 sparse", b, 1, 4, 0);
    exp_slice("R7 sparse", b + 1, 3, 4, 0);
  endtask

  // R4 R8: small slices and beat trimming at slice and transfer ends
  task automatic t_slice();
    int b;
    write_code(0, 0);
    b = ns;
    load(3, 0, 0, 0);
    wait_idle();
    chk("R4 code0 count", ns - b, 3);
    for (int k = 0; k < 3; k++) exp_slice("R8 code0", b + k, 0, 1, 1);
    write_code(1, 1);
    b = ns;
    load(0, 5, 0, 0);
    wait_idle();
    chk("R4 code1 count", ns - b, 3);
    exp_slice("R8 code1", b, 1, 2, 2);
    exp_slice("R8 code1", b + 1, 1, 2, 2);
    exp_slice("R8 code1 tail", b + 2, 1, 1, 1);
    write_code(2, 5);
    b = ns;
    load(0, 0, 70, 0);
    wait_idle();
    chk("R4 code5 count", ns - b, 3);
    exp_slice("R4 code5", b, 2, 32, 4);
    exp_slice("R4 code5", b + 1, 2, 32, 4);
    exp_slice("R9 code5 tail", b + 2, 2, 6, 4);
  endtask

  // R5: reserved codes saturate at 1024 bytes
  task automatic t_resv();
    int b;
    write_code(2, 'hC);
    b = ns;
    load(0, 0, 2500, 0);
    wait_idle();
    chk("R5 reserved count", ns - b, 3);
    exp_slice("R5 reserved", b, 2, 1024, 4);
    exp_slice("R5 reserved", b + 1, 2, 1024, 4);
    exp_slice("R5 reserved tail", b + 2, 2, 452, 4);
  endtask

  // R6: code 15 holder locks out another requester
  task automatic t_lock();
    int b;
    write_code(0, 'hF);
    write_code(1, 2);
    b = ns;
    load(300, 8, 0, 0);
    wait_idle();
    chk("R6 lock count", ns - b, 3);
    exp_slice("R6 lock holder", b, 0, 300, 4);
    exp_slice("R6 after lock", b + 1, 1, 4, 0);
    exp_slice("R6 after lock", b + 2, 1, 4, 0);
  endtask

  // R10: code change during a slice applies to the next grant only
  task automatic t_mid();
    int b;
    int n = 0;
    write_code(3, 3);
    b = ns;
    load(0, 0, 0, 16);
    while (gnt[3] != 1'b1 && n < 100) begin
      @(negedge clk);
      n++;
    end
    write_code(3, 0);
    wait_idle();
    chk("R10 count", ns - b, 9);
    exp_slice("R10 current slice", b, 3, 8, 4);
    exp_slice("R10 next slice", b + 1, 3, 1, 1);
  endtask

  // R8: only accepted beats count toward the slice
  task automatic t_stall();
    int b;
    int n = 0;
    write_code(0, 3);
    b = ns;
    load(12, 0, 0, 0);
    while (!(rem[0] == 0 && gnt == 4'b0) && n < 500) begin
      @(negedge clk);
      beat_ready = ~beat_ready;
      n++;
    end
    beat_ready = 1'b1;
    wait_idle();
    chk("R8 stall count", ns - b, 2);
    exp_slice("R8 stall", b, 0, 8, 4);
    exp_slice("R8 stall tail", b + 1, 0, 4, 4);
  endtask

  task automatic run_all();
    t_reset();
    t_regs();
    t_rr();
    t_slice();
    t_resv();
    t_lock();
    t_mid();
    t_stall();
  endtask

  initial begin
    rst_n      = 1'b0;
    cfg_we     = 1'b0;
    cfg_addr   = '0;
    cfg_wdata  = '0;
    beat_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule